// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is the combinational arithmetic and logic stage of a small accumulator machine. It works on a single 8-bit accumulator, or on a 16-bit pair of accumulators when the width select is high. Each cycle it takes two operands, an operation code and the current 8-bit condition-code register. It returns the result and the condition-code register that the operation produces. The register file and all sequencing sit outside the block.

The incoming carry is bit 0 of the condition-code input. Every flag that an operation does not define passes through unchanged. In byte mode the block ignores the upper operand bytes and drives the upper result byte to zero.

Condition-code layout, bit 7 down to bit 0: S (stop disable), X (interrupt mask), H (half carry), I (interrupt mask), N, Z, V, C.

Operation codes on `op_i`:

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | add with carry |
| 2 | subtract |
| 3 | subtract with borrow |
| 4 | negate |
| 5 | complement |
| 6 | clear |
| 7 | increment |
| 8 | decrement |
| 9 | AND |
| 10 | OR |
| 11 | XOR |
| 12 | logical shift right |
| 13 | arithmetic shift right |
| 14 | shift left |
| 15 | rotate right through carry |
| 16 | rotate left through carry |

Unary operations use `opa_i` only.

Top module: `alu_ccr`

## Requirements
- R1: Add (code 0) returns a+b and add with carry (code 1) returns a+b+C, both at the selected width (`wide_i`=1 for 16 bits). C (bit 0) is set when the unsigned sum exceeds 255 or 65535.
- R2: For byte-mode codes 0 and 1, H (bit 5) becomes the carry out of bit 3. For every other operation and width, H keeps its input value.
- R3: Subtract (code 2) returns a-b and subtract with borrow (code 3) returns a-b-C. C is set exactly when the true difference is below zero.
- R4: For codes 0, 1, 2, 3, 4, 7 and 8, V (bit 1) is set exactly when the two's-complement result is out of range at the selected width.
- R5: N (bit 3) equals the top bit of the result at the selected width. Z (bit 2) is set only when all result bits at that width are zero. In byte mode, result bits 15..8 are zero and operand bits 15..8 have no effect.
- R6: AND, OR and XOR (codes 9, 10, 11) clear V and leave C unchanged.
- R7: Negate (code 4) returns 0-a and sets C whenever the result is nonzero.
- R8: Complement (code 5) returns the inverted operand with C=1 and V=0. Clear (code 6) returns zero with N=0, Z=1, V=0, C=0.
- R9: Increment and decrement (codes 7 and 8) add or subtract one and leave C unchanged.
- R10: Logical right shift (code 12) fills the top bit with 0. Arithmetic right shift (code 13) keeps the top bit. Shift left (code 14) fills bit 0 with 0. The bit shifted out goes to C.
- R11: Rotates (codes 15 and 16) form a loop of width+1 bits through C. Nine byte rotates in the same direction restore both the operand and C.
- R12: After any shift or rotate, V equals N XOR C of the new flags.
- R13: S, X and I (bits 7, 6, 4) pass through unchanged for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | First operand; the only operand for unary operations |
| opb_i | input | 16 | Second operand |
| op_i | input | 5 | Operation code (0..16); codes above 16 give result 0 and an unchanged condition-code register |
| wide_i | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| ccr_i | input | 8 | Current condition-code register; bit 0 is the incoming carry |
| result_o | output | 16 | Result, zero-extended in byte mode |
| ccr_o | output | 8 | Updated condition-code register |

## Verification
The hardest situations to reach are those where a flag must survive an operation untouched. Examples are H across 16-bit and subtract operations, and C across logic, increment and decrement. From the ports alone these look the same as a flag that happens to be recomputed to the same value. The stimulus therefore presets each preserved flag to the value opposite to what a recomputation would yield.

The 9-bit rotate loop is exercised by feeding each result and carry back as the next inputs for nine rotates. The bench checks that the starting operand and carry return. A sweep of all codes with S, X and I both set and cleared covers the pass-through flags.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CCR_W  = 8;
  localparam int NIB_W  = 4;

  // condition-code bit positions
  localparam int CC_C = 0;
  localparam int CC_V = 1;
  localparam int CC_Z = 2;
  localparam int CC_N = 3;
  localparam int CC_I = 4;
  localparam int CC_H = 5;
  localparam int CC_X = 6;
  localparam int CC_S = 7;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_NEG = 5'd4,  OP_COM = 5'd5,  OP_CLR = 5'd6,  OP_INC = 5'd7,
    OP_DEC = 5'd8,  OP_AND = 5'd9,  OP_OR  = 5'd10, OP_XOR = 5'd11,
    OP_LSR = 5'd12, OP_ASR = 5'd13, OP_LSL = 5'd14, OP_ROR = 5'd15,
    OP_ROL = 5'd16
  } alu_op_e;

  typedef struct packed {
    logic [WORD_W-1:0] res;
    logic              c;
    logic              v;
    logic              h;
  } arith_t;

  typedef struct packed {
    logic [WORD_W-1:0] res;
    logic              c;
  } logic_t;
endpackage

// File: rtl/alu_arith_lane.sv
module alu_arith_lane
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  alu_op_e      op_i,
  output arith_t       out_o
);
  logic [W-1:0] x, y;
  logic         ci, borrow;
  logic [W-1:0] low;
  logic [1:0]   top;
  logic [NIB_W:0] nib;

  always_comb begin
    x = '0; y = '0; ci = 1'b0; borrow = 1'b0;
    unique case (op_i)
      OP_ADD: begin x = a_i; y = b_i; end
      OP_ADC: begin x = a_i; y = b_i; ci = cin_i; end
      OP_SUB: begin x = a_i; y = ~b_i; ci = 1'b1;    borrow = 1'b1; end
      OP_SBC: begin x = a_i; y = ~b_i; ci = ~cin_i;  borrow = 1'b1; end
      OP_NEG: begin y = ~a_i; ci = 1'b1;             borrow = 1'b1; end
      OP_INC: begin x = a_i; ci = 1'b1; end
      OP_DEC: begin x = a_i; y = '1; end
      default: ;
    endcase
  end

  // split at the msb to expose carry-in and carry-out of the top bit
  always_comb begin
    low = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + W'(ci);
    top = 2'(x[W-1]) + 2'(y[W-1]) + 2'(low[W-1]);
    nib = {1'b0, x[NIB_W-1:0]} + {1'b0, y[NIB_W-1:0]} + (NIB_W+1)'(ci);
    out_o.res = WORD_W'({top[0], low[W-2:0]});
    out_o.c   = top[1] ^ borrow;
    out_o.v   = top[1] ^ low[W-1];
    out_o.h   = nib[NIB_W];
  end
endmodule

// File: rtl/alu_logic_lane.sv
module alu_logic_lane
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  alu_op_e      op_i,
  output logic_t       out_o
);
  logic [W-1:0] r;
  logic         c;

  always_comb begin
    r = '0;
    c = cin_i;
    unique case (op_i)
      OP_COM: r = ~a_i;
      OP_AND: r = a_i & b_i;
      OP_OR:  r = a_i | b_i;
      OP_XOR: r = a_i ^ b_i;
      OP_LSR: begin r = {1'b0,     a_i[W-1:1]}; c = a_i[0];   end
      OP_ASR: begin r = {a_i[W-1], a_i[W-1:1]}; c = a_i[0];   end
      OP_LSL: begin r = {a_i[W-2:0], 1'b0};     c = a_i[W-1]; end
      OP_ROR: begin r = {cin_i, a_i[W-1:1]};    c = a_i[0];   end
      OP_ROL: begin r = {a_i[W-2:0], cin_i};    c = a_i[W-1]; end
      default: ;
    endcase
    out_o.res = WORD_W'(r);
    out_o.c   = c;
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic              wide_i,
  input  logic [CCR_W-1:0]  ccr_i,
  input  arith_t            ar_i,
  input  logic_t            lg_i,
  output logic [WORD_W-1:0] result_o,
  output logic [CCR_W-1:0]  ccr_o
);
  logic [WORD_W-1:0] r;
  logic              n, c_new;

  always_comb begin
    ccr_o = ccr_i;
    r     = '0;
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC: r = ar_i.res;
      OP_COM, OP_CLR, OP_AND, OP_OR, OP_XOR,
      OP_LSR, OP_ASR, OP_LSL, OP_ROR, OP_ROL:                 r = lg_i.res;
      default: ;
    endcase
    n = wide_i ? r[WORD_W-1] : r[BYTE_W-1];
    c_new = lg_i.c;

    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        ccr_o[CC_C] = ar_i.c;
        ccr_o[CC_V] = ar_i.v;
        if (!wide_i && (op_i == OP_ADD || op_i == OP_ADC)) ccr_o[CC_H] = ar_i.h;
      end
      OP_INC, OP_DEC:          ccr_o[CC_V] = ar_i.v;
      OP_COM:                  begin ccr_o[CC_C] = 1'b1; ccr_o[CC_V] = 1'b0; end
      OP_CLR:                  begin ccr_o[CC_C] = 1'b0; ccr_o[CC_V] = 1'b0; end
      OP_AND, OP_OR, OP_XOR:   ccr_o[CC_V] = 1'b0;
      OP_LSR, OP_ASR, OP_LSL, OP_ROR, OP_ROL: begin
        ccr_o[CC_C] = c_new;
        ccr_o[CC_V] = n ^ c_new;
      end
      default: ;
    endcase

    if (op_i <= OP_ROL) begin
      ccr_o[CC_N] = n;
      ccr_o[CC_Z] = (r == '0);
    end
    result_o = r;
  end
endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
  import alu_pkg::*;
(
  input  logic [15:0] opa_i,
  input  logic [15:0] opb_i,
  input  logic [4:0]  op_i,
  input  logic        wide_i,
  input  logic [7:0]  ccr_i,
  output logic [15:0] result_o,
  output logic [7:0]  ccr_o
);
  localparam int LANES = 2;

  alu_op_e op;
  arith_t  ar_lane [LANES];
  logic_t  lg_lane [LANES];

  assign op = alu_op_e'(op_i);

  // lane 0: byte width, lane 1: word width
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = BYTE_W << g;
    alu_arith_lane #(.W(LW)) u_arith (
      .a_i(opa_i[LW-1:0]), .b_i(opb_i[LW-1:0]), .cin_i(ccr_i[CC_C]),
      .op_i(op), .out_o(ar_lane[g])
    );
    alu_logic_lane #(.W(LW)) u_logic (
      .a_i(opa_i[LW-1:0]), .b_i(opb_i[LW-1:0]), .cin_i(ccr_i[CC_C]),
      .op_i(op), .out_o(lg_lane[g])
    );
  end

  alu_flags u_flags (
    .op_i(op), .wide_i(wide_i), .ccr_i(ccr_i),
    .ar_i(ar_lane[wide_i]), .lg_i(lg_lane[wide_i]),
    .result_o(result_o), .ccr_o(ccr_o)
  );
endmodule

// File: rtl/alu_ccr_chk.sv
module alu_ccr_chk (
  input logic [15:0] opa_i,
  input logic [4:0]  op_i,
  input logic        wide_i,
  input logic [7:0]  ccr_i,
  input logic [15:0] result_o,
  input logic [7:0]  ccr_o
);
  logic legal, shift_op, logic_op;
  assign legal    = (op_i <= 5'd16);
  assign shift_op = (op_i >= 5'd12) && legal;
  assign logic_op = (op_i >= 5'd9) && (op_i <= 5'd11);

  always_comb begin
    a_r13_sxi_pass: assert ({ccr_o[7:6], ccr_o[4]} == {ccr_i[7:6], ccr_i[4]})
      else $error("S/X/I changed");
    if (legal) begin
      a_r5_zero_flag: assert (ccr_o[2] == (result_o == 16'h0000))
        else $error("Z mismatch");
      a_r5_neg_flag: assert (ccr_o[3] == (wide_i ? result_o[15] : result_o[7]))
        else $error("N mismatch");
    end
    if (!wide_i) begin
      a_r5_byte_upper_zero: assert (result_o[15:8] == 8'h00)
        else $error("upper byte nonzero");
    end
    if (logic_op) begin
      a_r6_logic_cv: assert (!ccr_o[1] && ccr_o[0] == ccr_i[0])
        else $error("logic V/C");
    end
    if (op_i == 5'd5) begin
      a_r8_com_cv: assert (ccr_o[1:0] == 2'b01) else $error("COM V/C");
    end
    if (op_i == 5'd6) begin
      a_r8_clr_flags: assert (ccr_o[3:0] == 4'b0100 && result_o == 16'h0)
        else $error("CLR flags");
    end
    if (op_i == 5'd7 || op_i == 5'd8) begin
      a_r9_incdec_c: assert (ccr_o[0] == ccr_i[0]) else $error("INC/DEC C");
    end
    if (op_i == 5'd12 || op_i == 5'd13 || op_i == 5'd15) begin
      a_r10_right_c: assert (ccr_o[0] == opa_i[0]) else $error("right shift C");
    end
    if (shift_op) begin
      a_r12_shift_v: assert (ccr_o[1] == (ccr_o[3] ^ ccr_o[0]))
        else $error("shift V");
    end
    if (wide_i || op_i > 5'd1) begin
      a_r2_h_hold: assert (ccr_o[5] == ccr_i[5]) else $error("H changed");
    end
  end
endmodule

bind alu_ccr alu_ccr_chk u_chk (
  .opa_i(opa_i), .op_i(op_i), .wide_i(wide_i), .ccr_i(ccr_i),
  .result_o(result_o), .ccr_o(ccr_o)
);

// File: tb/alu_ccr_bench.sv
module alu_ccr_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] opa, opb, result;
  logic [4:0]  op;
  logic        wide;
  logic [7:0]  ccr_in, ccr_out;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  alu_ccr u_alu_ccr (
    .opa_i(opa), .opb_i(opb), .op_i(op), .wide_i(wide), .ccr_i(ccr_in),
    .result_o(result), .ccr_o(ccr_out)
  );

  // {op, wide, ccr_in, a, b, exp_res, exp_ccr}
  localparam int NV = 24;
  localparam logic [69:0] VEC [NV] = '{
    {5'd0,  1'b0, 8'h00, 16'h003A, 16'h0048, 16'h0082, 8'h2A}, // R1 R2 R4
    {5'd1,  1'b0, 8'h01, 16'h00FF, 16'h0000, 16'h0000, 8'h25}, // R1 R2 R5
    {5'd0,  1'b1, 8'hD0, 16'h7FFF, 16'h0001, 16'h8000, 8'hDA}, // R1 R4 R13
    {5'd2,  1'b0, 8'h00, 16'h0010, 16'h0020, 16'h00F0, 8'h09}, // R3
    {5'd3,  1'b0, 8'h01, 16'h0080, 16'h0000, 16'h007F, 8'h02}, // R3 R4
    {5'd2,  1'b1, 8'h20, 16'h1234, 16'h1234, 16'h0000, 8'h24}, // R3 R2 R5
    {5'd4,  1'b0, 8'h00, 16'h0080, 16'h0000, 16'h0080, 8'h0B}, // R7 R4
    {5'd4,  1'b0, 8'h01, 16'h0000, 16'h0000, 16'h0000, 8'h04}, // R7
    {5'd5,  1'b0, 8'h02, 16'h005A, 16'h0000, 16'h00A5, 8'h09}, // R8
    {5'd6,  1'b1, 8'hFF, 16'hFFFF, 16'h0000, 16'h0000, 8'hF4}, // R8 R13
    {5'd7,  1'b0, 8'h01, 16'h007F, 16'h0000, 16'h0080, 8'h0B}, // R9 R4
    {5'd8,  1'b0, 8'h00, 16'h0000, 16'h0000, 16'h00FF, 8'h08}, // R9
    {5'd8,  1'b1, 8'h01, 16'h8000, 16'h0000, 16'h7FFF, 8'h03}, // R9 R4
    {5'd9,  1'b0, 8'h03, 16'h00F0, 16'h000F, 16'h0000, 8'h05}, // R6
    {5'd10, 1'b1, 8'h02, 16'h8000, 16'h0001, 16'h8001, 8'h08}, // R6
    {5'd11, 1'b0, 8'h01, 16'h00FF, 16'h000F, 16'h00F0, 8'h09}, // R6
    {5'd12, 1'b0, 8'h00, 16'h0081, 16'h0000, 16'h0040, 8'h03}, // R10 R12
    {5'd13, 1'b0, 8'h00, 16'h0081, 16'h0000, 16'h00C0, 8'h09}, // R10 R12
    {5'd14, 1'b1, 8'h00, 16'h8001, 16'h0000, 16'h0002, 8'h03}, // R10 R12
    {5'd15, 1'b0, 8'h01, 16'h0002, 16'h0000, 16'h0081, 8'h0A}, // R11 R12
    {5'd16, 1'b0, 8'h00, 16'h0080, 16'h0000, 16'h0000, 8'h07}, // R11 R12
    {5'd16, 1'b1, 8'h01, 16'h4000, 16'h0000, 16'h8001, 8'h0A}, // R11
    {5'd13, 1'b1, 8'h00, 16'h8000, 16'h0000, 16'hC000, 8'h0A}, // R10
    {5'd0,  1'b0, 8'h00, 16'hAB01, 16'hCD01, 16'h0002, 8'h00}  // R5 upper bytes ignored
  };

  task automatic apply(input logic [4:0] o, input logic w, input logic [7:0] c,
                       input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    op = o; wide = w; ccr_in = c; opa = a; opb = b;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [15:0] exp_r,
                       input logic [7:0] exp_c);
    checks++;
    if (result !== exp_r || ccr_out !== exp_c) begin
      errors++;
      $display("FAIL %s: result %h ccr %h, expected result %h ccr %h",
               tag, result, ccr_out, exp_r, exp_c);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  c;
    op = '0; wide = 1'b0; ccr_in = '0; opa = '0; opb = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // idle inputs: add of zeros sets only Z (R5)
    apply(5'd0, 1'b0, 8'h00, 16'h0000, 16'h0000);
    check("R5 idle", 16'h0000, 8'h04);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][69:65], VEC[i][64], VEC[i][63:56], VEC[i][55:40], VEC[i][39:24]);
      check($sformatf("vector %0d", i), VEC[i][23:8], VEC[i][7:0]);
    end

    // R13: S, X, I pass through on every code
    for (int k = 0; k <= 16; k++) begin
      for (int s = 0; s < 2; s++) begin
        apply(5'(k), 1'(s), s ? 8'hD0 : 8'h00, 16'h1357, 16'h2468);
        checks++;
        if ((ccr_out & 8'hD0) !== (s ? 8'hD0 : 8'h00)) begin
          errors++;
          $display("FAIL R13 op %0d: ccr %h, expected SXI %h", k, ccr_out,
                   s ? 8'hD0 : 8'h00);
        end
      end
    end

    // R11: nine byte rotates restore operand and carry
    for (int d = 0; d < 2; d++) begin
      v = 16'h005A; c = 8'h00;
      for (int n = 0; n < 9; n++) begin
        apply(d ? 5'd16 : 5'd15, 1'b0, c, v, 16'h0000);
        v = result; c = ccr_out & 8'h01;
      end
      checks++;
      if (v !== 16'h005A || c[0] !== 1'b0) begin
        errors++;
        $display("FAIL R11 dir %0d: value %h C %b, expected 005A C 0", d, v, c[0]);
      end
    end

    // R2: H untouched by a byte subtract that borrows from bit 4
    apply(5'd2, 1'b0, 8'h20, 16'h0010, 16'h0001);
    check("R2 sub holds H", 16'h000F, 8'h20);
    // R9: increment wrap leaves C clear
    apply(5'd7, 1'b1, 8'h00, 16'hFFFF, 16'h0000);
    check("R9 inc wrap", 16'h0000, 8'h04);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule